// File: doc/BRIEF.md
# Multiported Register File with Write Buffer Bypass

This block is the central register file of an eight-ALU wide-issue datapath. It stores 64 registers of 33 bits. In every cycle it takes up to eight results, one per ALU, and serves sixteen operand reads, two per ALU. Results are not written into storage in the cycle they arrive. They are first latched into a one-stage write buffer, and the array write happens on the following clock edge.

While a result waits in the buffer, each read port compares its address with every valid buffered destination. On a match, the read port returns the buffered value, so a consumer sees a producer's result in the very next cycle. Each read port can also choose an immediate operand in place of register data.

The storage is built as two identical arrays, each with eight write ports and eight read ports. Both arrays take every committed write. Read ports 0 to 7 are served by the first array and read ports 8 to 15 by the second. Read addresses are expected to come from an upstream pipeline register, and the read path itself is combinational.

Top module: `mrf_bypass_rf`

## Requirements
- R1: While `rst_ni` is low, all write-buffer valid bits are cleared at once. Results that were pending when reset arrived are never committed, so after reset the affected registers still read their earlier contents.
- R2: The array holds 64 registers of 33 bits each. A committed value reads back unchanged on every later cycle until the register is written again.
- R3: A result presented with its enable bit set in cycle n is not visible to reads in cycle n. Reads in cycle n+1 return it through the bypass, and reads from cycle n+2 onward return it from the array.
- R4: Any of the 16 read ports whose address matches a valid buffered destination returns that buffered data in place of the array contents.
- R5: If several write ports target the same register in one cycle, the highest-numbered port's data is the value that is bypassed and the value that is committed.
- R6: When a read port's `rd_imm_sel_i` bit is 1, that port outputs its own `rd_imm_i` word, whatever its address and any pending write.
- R7: Every write reaches both arrays, so read ports 0 to 7 and read ports 8 to 15 return identical data for identical addresses.
- R8: A write port whose `wr_en_i` bit is 0 has no effect on any register or on any read result, whatever its address and data inputs hold.
- R9: Writes to the same register in back-to-back cycles are observed in order. The second cycle's reads see the first value, and the third cycle's reads see the second value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the write-buffer valid bits |
| wr_en_i | input | 8 | Per write port: result is valid this cycle |
| wr_addr_i | input | 8x6 | Per write port: destination register |
| wr_data_i | input | 8x33 | Per write port: result data |
| rd_addr_i | input | 16x6 | Per read port: source register (ports 0-7 use array 0, ports 8-15 use array 1) |
| rd_imm_sel_i | input | 16 | Per read port: 1 selects the immediate operand |
| rd_imm_i | input | 16x33 | Per read port: immediate operand |
| rd_data_o | output | 16x33 | Per read port: operand data |

## Verification
A first sequence fills every register, then sweeps addresses across all sixteen ports. This separates a missing commit or a wrong copy from a wrong address decode. Directed sequences follow one result through its three phases: invisible in its own cycle, bypassed in the next, and stored afterwards. They also load all eight write ports onto a single register, which shows whether the buffer and the array resolve the conflict in the same way. Immediate selection on a port with a pending match, disabled ports carrying live-looking data, back-to-back rewrites and a reset arriving over pending results each target one ordering rule. A long random phase confined to a narrow address window then produces dense multi-port hits.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_IMM    = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rf_wbuf.sv
module rf_wbuf #(
  parameter int NW = 8,
  parameter int AW = 6,
  parameter int DW = 33
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NW-1:0]          wr_en_i,
  input  logic [NW-1:0][AW-1:0]  wr_addr_i,
  input  logic [NW-1:0][DW-1:0]  wr_data_i,
  output logic [NW-1:0]          wb_vld_o,
  output logic [NW-1:0][AW-1:0]  wb_addr_o,
  output logic [NW-1:0][DW-1:0]  wb_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wb_vld_o <= '0;
    else         wb_vld_o <= wr_en_i;
  end

  // payload needs no reset: qualified by valid
  always_ff @(posedge clk_i) begin
    wb_addr_o <= wr_addr_i;
    wb_data_o <= wr_data_i;
  end

  for (genvar p = 0; p < NW; p++) begin : g_chk
    // R3
    wbuf_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_vld_o[p] |-> $past(wr_en_i[p]));
    // R3
    wbuf_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[p] |=> (wb_addr_o[p] == $past(wr_addr_i[p]) &&
                      wb_data_o[p] == $past(wr_data_i[p])));
  end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int NREGS = 64,
  parameter int NW    = 8,
  parameter int NR    = 8,
  parameter int DW    = 33,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic                   clk_i,
  input  logic [NW-1:0]          wb_vld_i,
  input  logic [NW-1:0][AW-1:0]  wb_addr_i,
  input  logic [NW-1:0][DW-1:0]  wb_data_i,
  input  logic [NR-1:0][AW-1:0]  rd_addr_i,
  output logic [NR-1:0][DW-1:0]  rd_data_o
);

  logic [DW-1:0] mem_q [NREGS];

  // ascending loop: last assignment, highest port, wins
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NW; p++) begin
      if (wb_vld_i[p]) mem_q[wb_addr_i[p]] <= wb_data_i[p];
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_addr_i[r]];
  end

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_pkg::*;
#(
  parameter int NW = 8,
  parameter int AW = 6,
  parameter int DW = 33
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          rd_addr_i,
  input  logic                   rd_imm_sel_i,
  input  logic [DW-1:0]          rd_imm_i,
  input  logic [DW-1:0]          arr_data_i,
  input  logic [NW-1:0]          wb_vld_i,
  input  logic [NW-1:0][AW-1:0]  wb_addr_i,
  input  logic [NW-1:0][DW-1:0]  wb_data_i,
  output logic [DW-1:0]          rd_data_o
);

  logic [NW-1:0] hit, hit_sel;
  logic [DW-1:0] byp_data;
  rd_src_e       src;

  for (genvar p = 0; p < NW; p++) begin : g_cmp
    assign hit[p] = wb_vld_i[p] && (wb_addr_i[p] == rd_addr_i);
  end

  // keep only the highest matching port
  always_comb begin
    hit_sel = '0;
    for (int p = 0; p < NW; p++) begin
      if (hit[p]) begin
        hit_sel    = '0;
        hit_sel[p] = 1'b1;
      end
    end
  end

  always_comb begin
    byp_data = '0;
    for (int p = 0; p < NW; p++) begin
      byp_data |= {DW{hit_sel[p]}} & wb_data_i[p];
    end
  end

  assign src = rd_imm_sel_i ? SRC_IMM : (|hit) ? SRC_BYPASS : SRC_ARRAY;

  always_comb begin
    unique case (src)
      SRC_IMM:    rd_data_o = rd_imm_i;
      SRC_BYPASS: rd_data_o = byp_data;
      default:    rd_data_o = arr_data_i;
    endcase
  end

  // R6
  imm_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_imm_sel_i |-> rd_data_o == rd_imm_i);
  // R2
  arr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_imm_sel_i && !(|(wb_vld_i & hit))) |-> rd_data_o == arr_data_i);
  // R5
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_sel));

endmodule

// File: rtl/mrf_bypass_rf.sv
module mrf_bypass_rf #(
  parameter int NUM_REGS   = 64,
  parameter int DATA_W     = 33,
  parameter int NUM_WR     = 8,
  parameter int NUM_RD     = 16,
  parameter int NUM_COPIES = 2,
  localparam int AW        = $clog2(NUM_REGS),
  localparam int RD_PER_CP = NUM_RD / NUM_COPIES
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WR-1:0]             wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]     wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data_i,
  input  logic [NUM_RD-1:0][AW-1:0]     rd_addr_i,
  input  logic [NUM_RD-1:0]             rd_imm_sel_i,
  input  logic [NUM_RD-1:0][DATA_W-1:0] rd_imm_i,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o
);

  logic [NUM_WR-1:0]             wb_vld;
  logic [NUM_WR-1:0][AW-1:0]     wb_addr;
  logic [NUM_WR-1:0][DATA_W-1:0] wb_data;
  logic [NUM_RD-1:0][DATA_W-1:0] arr_rd;

  rf_wbuf #(.NW(NUM_WR), .AW(AW), .DW(DATA_W)) u_wbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wb_vld_o  (wb_vld),
    .wb_addr_o (wb_addr),
    .wb_data_o (wb_data)
  );

  // each copy takes every write and serves its own slice of read ports
  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
    rf_bank #(
      .NREGS (NUM_REGS),
      .NW    (NUM_WR),
      .NR    (RD_PER_CP),
      .DW    (DATA_W),
      .AW    (AW)
    ) u_bank (
      .clk_i     (clk_i),
      .wb_vld_i  (wb_vld),
      .wb_addr_i (wb_addr),
      .wb_data_i (wb_data),
      .rd_addr_i (rd_addr_i[c*RD_PER_CP +: RD_PER_CP]),
      .rd_data_o (arr_rd[c*RD_PER_CP +: RD_PER_CP])
    );
  end

  for (genvar i = 0; i < NUM_RD; i++) begin : g_port
    rf_rd_port #(.NW(NUM_WR), .AW(AW), .DW(DATA_W)) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .rd_addr_i    (rd_addr_i[i]),
      .rd_imm_sel_i (rd_imm_sel_i[i]),
      .rd_imm_i     (rd_imm_i[i]),
      .arr_data_i   (arr_rd[i]),
      .wb_vld_i     (wb_vld),
      .wb_addr_i    (wb_addr),
      .wb_data_i    (wb_data),
      .rd_data_o    (rd_data_o[i])
    );
  end

endmodule

// File: tb/mrf_bypass_rf_test.sv
`timescale 1ns/1ps
module mrf_bypass_rf_test;
  localparam int NREGS = 64;
  localparam int DW    = 33;
  localparam int NW    = 8;
  localparam int NR    = 16;
  localparam int AW    = 6;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [NW-1:0]         wr_en;
  logic [NW-1:0][AW-1:0] wr_addr;
  logic [NW-1:0][DW-1:0] wr_data;
  logic [NR-1:0][AW-1:0] rd_addr;
  logic [NR-1:0]         rd_imm_sel;
  logic [NR-1:0][DW-1:0] rd_imm;
  logic [NR-1:0][DW-1:0] rd_data;

  always #2.5 clk_i = ~clk_i;

  mrf_bypass_rf uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .rd_addr_i    (rd_addr),
    .rd_imm_sel_i (rd_imm_sel),
    .rd_imm_i     (rd_imm),
    .rd_data_o    (rd_data)
  );

  logic [DW-1:0] ref_mem [NREGS];
  logic          pv [NW];
  logic [AW-1:0] pa [NW];
  logic [DW-1:0] pd [NW];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom_range(1, 0), $urandom()};
  endfunction

  function automatic logic [DW-1:0] exp_rd(int i);
    logic [DW-1:0] v;
    if (rd_imm_sel[i]) return rd_imm[i];
    v = ref_mem[rd_addr[i]];
    for (int p = 0; p < NW; p++)
      if (pv[p] && pa[p] == rd_addr[i]) v = pd[p];
    return v;
  endfunction

  task automatic check_reads(string tag);
    for (int i = 0; i < NR; i++) begin
      logic [DW-1:0] e;
      e = exp_rd(i);
      n_chk++;
      if (rd_data[i] !== e) begin
        n_fail++;
        $display("FAIL %s port %0d addr %0d: got %h exp %h", tag, i, rd_addr[i], rd_data[i], e);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    for (int p = 0; p < NW; p++)
      if (pv[p]) ref_mem[pa[p]] = pd[p];
    for (int p = 0; p < NW; p++) begin
      pv[p] = rst_ni && wr_en[p];
      pa[p] = wr_addr[p];
      pd[p] = wr_data[p];
    end
    @(negedge clk_i);
  endtask

  task automatic step(string tag, bit chk);
    #1;
    if (chk) check_reads(tag);
    tick();
  endtask

  task automatic idle_ports();
    wr_en = '0;
    rd_imm_sel = '0;
    for (int p = 0; p < NW; p++) begin
      wr_addr[p] = AW'($urandom_range(NREGS-1, 0));
      wr_data[p] = rnd_word();
    end
    for (int i = 0; i < NR; i++) begin
      rd_imm[i] = rnd_word();
      rd_addr[i] = AW'(i);
    end
  endtask

  task automatic all_read(int a);
    for (int i = 0; i < NR; i++) rd_addr[i] = AW'(a);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NW; p++) pv[p] = 1'b0;
    idle_ports();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: fill every register
    for (int b = 0; b < NREGS / NW; b++) begin
      idle_ports();
      for (int p = 0; p < NW; p++) begin
        wr_en[p] = 1'b1;
        wr_addr[p] = AW'(b * NW + p);
        wr_data[p] = rnd_word();
      end
      step("R2", 0);
    end
    idle_ports();
    step("R2", 0);
    // R2: sweep all registers on all ports
    for (int k = 0; k < NREGS / NR; k++) begin
      idle_ports();
      for (int i = 0; i < NR; i++) rd_addr[i] = AW'(k * NR + i);
      step("R2", 1);
    end

    // R3: invisible in own cycle, bypassed next, stored after
    idle_ports(); all_read(10);
    wr_en[3] = 1'b1; wr_addr[3] = 6'd10; wr_data[3] = 33'h1_2345_6789;
    step("R3", 1);
    idle_ports(); all_read(10);
    step("R3", 1);
    idle_ports(); all_read(10);
    step("R3", 1);

    // R4: eight pending results fanned out to all 16 ports
    idle_ports();
    for (int p = 0; p < NW; p++) begin
      wr_en[p] = 1'b1; wr_addr[p] = AW'(20 + p); wr_data[p] = rnd_word();
    end
    step("R4", 0);
    idle_ports();
    for (int i = 0; i < NR; i++) rd_addr[i] = AW'(20 + ((i * 3) % NW));
    step("R4", 1);

    // R5: all ports hit one register
    idle_ports();
    for (int p = 0; p < NW; p++) begin
      wr_en[p] = 1'b1; wr_addr[p] = 6'd40; wr_data[p] = {1'b0, 32'hA0A0_0000} + DW'(p);
    end
    step("R5", 0);
    idle_ports(); all_read(40);
    #1;
    n_chk++;
    if (rd_data[0] !== ({1'b0, 32'hA0A0_0000} + DW'(7))) begin
      n_fail++;
      $display("FAIL R5 bypass winner: got %h exp %h", rd_data[0], {1'b0, 32'hA0A0_0000} + DW'(7));
    end
    step("R5", 1);
    idle_ports(); all_read(40);
    step("R5", 1);

    // R6: immediate overrides a pending match
    idle_ports(); wr_en[1] = 1'b1; wr_addr[1] = 6'd12; wr_data[1] = rnd_word();
    step("R6", 0);
    idle_ports(); all_read(12);
    for (int i = 0; i < NR; i += 2) rd_imm_sel[i] = 1'b1;
    step("R6", 1);

    // R7: a write reaches both copies
    idle_ports(); wr_en[0] = 1'b1; wr_addr[0] = 6'd63; wr_data[0] = 33'h1_FFFF_0001;
    step("R7", 0);
    idle_ports(); step("R7", 0);
    idle_ports(); all_read(63);
    #1;
    n_chk++;
    if (rd_data[0] !== rd_data[NR-1] || rd_data[NR-1] !== 33'h1_FFFF_0001) begin
      n_fail++;
      $display("FAIL R7 copies: got %h/%h exp %h", rd_data[0], rd_data[NR-1], 33'h1_FFFF_0001);
    end
    step("R7", 1);

    // R8: disabled ports carry data but change nothing
    idle_ports();
    for (int p = 0; p < NW; p++) begin
      wr_addr[p] = 6'd30; wr_data[p] = rnd_word();
    end
    all_read(30);
    step("R8", 1);
    idle_ports(); all_read(30);
    step("R8", 1);
    idle_ports(); all_read(30);
    step("R8", 1);

    // R9: back-to-back writes to one register
    idle_ports(); all_read(50);
    wr_en[2] = 1'b1; wr_addr[2] = 6'd50; wr_data[2] = 33'h0_AAAA_0001;
    step("R9", 1);
    idle_ports(); all_read(50);
    wr_en[5] = 1'b1; wr_addr[5] = 6'd50; wr_data[5] = 33'h1_BBBB_0002;
    step("R9", 1);
    idle_ports(); all_read(50);
    step("R9", 1);
    idle_ports(); all_read(50);
    step("R9", 1);

    // R1: reset drops pending results
    idle_ports(); all_read(5);
    wr_en[2] = 1'b1; wr_addr[2] = 6'd5; wr_data[2] = 33'h1_DEAD_BEEF;
    step("R1", 1);
    rst_ni = 1'b0;
    idle_ports(); all_read(5);
    for (int p = 0; p < NW; p++) pv[p] = 1'b0;
    #1;
    check_reads("R1");
    tick();
    rst_ni = 1'b1;
    idle_ports(); all_read(5);
    step("R1", 1);
    idle_ports(); all_read(5);
    step("R1", 1);

    // R4: random traffic in a narrow window for dense hits
    for (int c = 0; c < 400; c++) begin
      int base;
      base = (c < 200) ? 0 : 56;
      idle_ports();
      for (int p = 0; p < NW; p++) begin
        wr_en[p] = 1'($urandom_range(1, 0));
        wr_addr[p] = AW'(base + $urandom_range(7, 0));
      end
      for (int i = 0; i < NR; i++) begin
        rd_addr[i] = AW'(base + $urandom_range(7, 0));
        rd_imm_sel[i] = ($urandom_range(7, 0) == 0);
      end
      step("R4", 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule